// File: doc/BRIEF.md
# Bundled-Data to One-Hot Channel Bridge

This block connects a four-phase bundled-data channel to a delay-insensitive channel built from 1-of-4 one-hot groups, and it also converts in the opposite direction. On the forward path, a word offered with a request is spread over groups of four rails. Each pair of data bits raises exactly one rail in its group. The receiver then answers on a single acknowledge wire that covers the whole word, and the bridge returns every rail to zero. On the return path, a one-hot word arriving on the input rails is collected and offered to a bundled-data sink with a request. It is acknowledged on the one-hot side only after the sink has accepted it.

A completion detector watches the incoming rails. It reports when every group holds a legal code and when every group has gone back to empty. A group with two or more rails high is illegal and latches a sticky error. The whole block is a clocked model that samples the handshake wires on every rising edge. It is meant for a synchronous bench or a synchronous wrapper around a clockless link.

Top module: `oh_channel_bridge`

## Requirements
- R1: On the forward path, bits [2g+1:2g] of the word with value v raise rail 4g+v of output group g and no other rail of that group. Every output group is then valid at the same time.
- R2: The forward rails are all low (empty) except between offering a word and seeing it acknowledged. On the edge that accepts the one-hot acknowledge, every rail returns to zero.
- R3: The forward rails become valid one cycle after an edge that sees the source request high and the one-hot acknowledge low. The source acknowledge rises only on an edge that sees the one-hot acknowledge high while all output groups are valid. It falls one cycle after an edge that sees both the source request and the one-hot acknowledge low.
- R4: While the one-hot acknowledge stays low, the offered rails hold their value.
- R5: One complete forward transfer of a DATA_W-bit word makes exactly DATA_W rail transitions plus two acknowledge transitions (DATA_W+2), whatever the data value.
- R6: On the return path, the sink request rises one cycle after an edge that sees every input group valid and the sink acknowledge low, with the decoded word on the sink data. A word with any group still empty raises no request.
- R7: The one-hot acknowledge on the return path rises only after the sink acknowledge is seen high. The sink request falls on that same edge.
- R8: The return-path one-hot acknowledge falls one cycle after an edge that sees every input group empty and the sink acknowledge low.
- R9: The completion outputs are combinational in the input rails. The full output is high exactly when every group has one rail high. The empty output is high exactly when all rails are low.
- R10: Any input group with more than one rail high sets the error output on the next edge. The error then stays set until reset.
- R11: With reset asserted (active low), all forward rails, both acknowledges, the sink request and the error output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 1 | Bundled source request |
| src_data_i | input | DATA_W | Bundled source word |
| src_ack_o | output | 1 | Acknowledge to bundled source |
| txr_rails_o | output | 2*DATA_W | Forward one-hot rails, four per bit pair |
| txr_ack_i | input | 1 | Acknowledge from one-hot receiver |
| rxr_rails_i | input | 2*DATA_W | Incoming one-hot rails |
| rxr_ack_o | output | 1 | Acknowledge to one-hot sender |
| snk_req_o | output | 1 | Bundled sink request |
| snk_data_o | output | DATA_W | Bundled sink word |
| snk_ack_i | input | 1 | Acknowledge from bundled sink |
| rx_full_o | output | 1 | Every incoming group holds a legal code |
| rx_empty_o | output | 1 | Every incoming rail is low |
| rx_err_o | output | 1 | Sticky illegal-code flag |

## Verification
Both paths are swept over every value of a 4-bit word. The forward sweep shows that each bit pair lands on its own rail and that the transition count does not depend on the data. The return sweep shows that decoding is correct for each code and that the handshakes are ordered. A word with only some groups valid is held back, which separates "some groups ready" from "whole word ready". All 256 input rail patterns are then applied. They are compared with arithmetically computed full, empty and illegal flags, which tell legal codes apart from the empty state and from multi-rail codes. This sweep also shows that the error stays latched once set.

// File: rtl/oh_bridge_pkg.sv
`timescale 1ns/1ps
package oh_bridge_pkg;
  localparam int unsigned GRP_RAILS = 4;

  typedef enum logic [1:0] {TX_IDLE, TX_HOLD, TX_RTZ} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_OFFER, RX_RTZ} rx_state_e;

  function automatic logic [GRP_RAILS-1:0] pair_to_rails(input logic [1:0] v);
    return 4'b0001 << v;
  endfunction

  function automatic logic [1:0] rails_to_pair(input logic [GRP_RAILS-1:0] r);
    return {r[3] | r[2], r[3] | r[1]};
  endfunction
endpackage

// File: rtl/oh_completion.sv
`timescale 1ns/1ps
module oh_completion #(
  parameter int GROUPS = 4
) (
  input  logic [4*GROUPS-1:0] rails_i,
  output logic                all_valid_o,
  output logic                all_empty_o,
  output logic                any_multi_o
);
  logic [GROUPS-1:0] grp_any;
  logic [GROUPS-1:0] grp_multi;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [3:0] r;
    assign r            = rails_i[4*g +: 4];
    assign grp_any[g]   = |r;
    assign grp_multi[g] = (r[0] & (r[1] | r[2] | r[3])) |
                          (r[1] & (r[2] | r[3])) |
                          (r[2] & r[3]);
  end

  assign all_valid_o = &(grp_any & ~grp_multi);
  assign all_empty_o = ~|grp_any;
  assign any_multi_o = |grp_multi;
endmodule

// File: rtl/oh_word_codec.sv
`timescale 1ns/1ps
module oh_word_codec
  import oh_bridge_pkg::*;
#(
  parameter int GROUPS = 4
) (
  input  logic [2*GROUPS-1:0] enc_data_i,
  output logic [4*GROUPS-1:0] enc_rails_o,
  input  logic [4*GROUPS-1:0] dec_rails_i,
  output logic [2*GROUPS-1:0] dec_data_o
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_pair
    assign enc_rails_o[4*g +: 4] = pair_to_rails(enc_data_i[2*g +: 2]);
    assign dec_data_o[2*g +: 2]  = rails_to_pair(dec_rails_i[4*g +: 4]);
  end
endmodule

// File: rtl/oh_tx_fsm.sv
`timescale 1ns/1ps
module oh_tx_fsm
  import oh_bridge_pkg::*;
#(
  parameter int RAIL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_req_i,
  input  logic [RAIL_W-1:0] enc_rails_i,
  output logic              src_ack_o,
  output logic [RAIL_W-1:0] txr_rails_o,
  input  logic              txr_ack_i,
  input  logic              txr_full_i
);
  tx_state_e         state_q, state_d;
  logic [RAIL_W-1:0] rails_q, rails_d;
  logic              ack_q, ack_d;
  logic              rails_en, ack_en;

  always_comb begin
    state_d  = state_q;
    rails_d  = rails_q;
    ack_d    = ack_q;
    rails_en = 1'b0;
    ack_en   = 1'b0;
    case (state_q)
      TX_IDLE: if (src_req_i && !txr_ack_i) begin
        rails_d  = enc_rails_i;
        rails_en = 1'b1;
        state_d  = TX_HOLD;
      end
      TX_HOLD: if (txr_ack_i && txr_full_i) begin
        rails_d  = '0;
        rails_en = 1'b1;
        ack_d    = 1'b1;
        ack_en   = 1'b1;
        state_d  = TX_RTZ;
      end
      TX_RTZ: if (!src_req_i && !txr_ack_i) begin
        ack_d   = 1'b0;
        ack_en  = 1'b1;
        state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      rails_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rails_en) rails_q <= rails_d;
      if (ack_en)   ack_q   <= ack_d;
    end
  end

  assign src_ack_o   = ack_q;
  assign txr_rails_o = rails_q;

  a_r3_ack_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_ack_o) |-> $past(txr_ack_i && txr_full_i));
  a_r2_rtz_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_ack_o) |-> (txr_rails_o == '0));
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (txr_full_i && !txr_ack_i) |=> $stable(txr_rails_o));
endmodule

// File: rtl/oh_rx_fsm.sv
`timescale 1ns/1ps
module oh_rx_fsm
  import oh_bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxr_full_i,
  input  logic              rxr_empty_i,
  input  logic              rxr_multi_i,
  input  logic [DATA_W-1:0] dec_data_i,
  output logic              rxr_ack_o,
  output logic              snk_req_o,
  output logic [DATA_W-1:0] snk_data_o,
  input  logic              snk_ack_i,
  output logic              err_o
);
  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;
  logic              req_q, req_d, req_en;
  logic              ack_q, ack_d, ack_en;
  logic              err_q, err_en;

  always_comb begin
    state_d = state_q;
    data_en = 1'b0;
    req_d   = req_q;
    req_en  = 1'b0;
    ack_d   = ack_q;
    ack_en  = 1'b0;
    case (state_q)
      RX_IDLE: if (rxr_full_i && !snk_ack_i) begin
        data_en = 1'b1;
        req_d   = 1'b1;
        req_en  = 1'b1;
        state_d = RX_OFFER;
      end
      RX_OFFER: if (snk_ack_i) begin
        req_d   = 1'b0;
        req_en  = 1'b1;
        ack_d   = 1'b1;
        ack_en  = 1'b1;
        state_d = RX_RTZ;
      end
      RX_RTZ: if (rxr_empty_i && !snk_ack_i) begin
        ack_d   = 1'b0;
        ack_en  = 1'b1;
        state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
    err_en = rxr_multi_i && !err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      data_q  <= '0;
      req_q   <= 1'b0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (data_en) data_q <= dec_data_i;
      if (req_en)  req_q  <= req_d;
      if (ack_en)  ack_q  <= ack_d;
      if (err_en)  err_q  <= 1'b1;
    end
  end

  assign snk_req_o  = req_q;
  assign snk_data_o = data_q;
  assign rxr_ack_o  = ack_q;
  assign err_o      = err_q;

  a_r7_ack_after_sink: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxr_ack_o) |-> $past(snk_ack_i));
  a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_req_o && $past(snk_req_o)) |-> $stable(snk_data_o));
  a_r8_drop_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxr_ack_o) |-> $past(rxr_empty_i));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_o) |-> err_o);
endmodule

// File: rtl/oh_channel_bridge.sv
`timescale 1ns/1ps
module oh_channel_bridge #(
  parameter  int DATA_W = 8,
  localparam int RAIL_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_req_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ack_o,
  output logic [RAIL_W-1:0] txr_rails_o,
  input  logic              txr_ack_i,
  input  logic [RAIL_W-1:0] rxr_rails_i,
  output logic              rxr_ack_o,
  output logic              snk_req_o,
  output logic [DATA_W-1:0] snk_data_o,
  input  logic              snk_ack_i,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  output logic              rx_err_o
);
  localparam int GROUPS = DATA_W / 2;

  if ((DATA_W % 2) != 0 || DATA_W < 2) begin : g_bad_width
    $error("DATA_W must be a positive even number");
  end

  logic [RAIL_W-1:0] enc_rails;
  logic [DATA_W-1:0] dec_data;
  logic              tx_full, tx_empty, tx_multi;
  logic              rx_multi;

  oh_word_codec #(.GROUPS(GROUPS)) u_codec (
    .enc_data_i (src_data_i),
    .enc_rails_o(enc_rails),
    .dec_rails_i(rxr_rails_i),
    .dec_data_o (dec_data)
  );

  oh_completion #(.GROUPS(GROUPS)) u_tx_cd (
    .rails_i    (txr_rails_o),
    .all_valid_o(tx_full),
    .all_empty_o(tx_empty),
    .any_multi_o(tx_multi)
  );

  oh_completion #(.GROUPS(GROUPS)) u_rx_cd (
    .rails_i    (rxr_rails_i),
    .all_valid_o(rx_full_o),
    .all_empty_o(rx_empty_o),
    .any_multi_o(rx_multi)
  );

  oh_tx_fsm #(.RAIL_W(RAIL_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req_i  (src_req_i),
    .enc_rails_i(enc_rails),
    .src_ack_o  (src_ack_o),
    .txr_rails_o(txr_rails_o),
    .txr_ack_i  (txr_ack_i),
    .txr_full_i (tx_full)
  );

  oh_rx_fsm #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxr_full_i (rx_full_o),
    .rxr_empty_i(rx_empty_o),
    .rxr_multi_i(rx_multi),
    .dec_data_i (dec_data),
    .rxr_ack_o  (rxr_ack_o),
    .snk_req_o  (snk_req_o),
    .snk_data_o (snk_data_o),
    .snk_ack_i  (snk_ack_i),
    .err_o      (rx_err_o)
  );

  // R1: forward rails always carry either a whole valid word or nothing
  a_r1_tx_whole_word: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_multi && (tx_full || tx_empty));
endmodule

// File: tb/oh_channel_bridge_tb.sv
`timescale 1ns/1ps
module oh_channel_bridge_tb;
  localparam int DATA_W = 4;
  localparam int RAIL_W = 2 * DATA_W;
  localparam int GROUPS = DATA_W / 2;
  localparam real CLK_PERIOD = 4.0;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              src_req_i, txr_ack_i, snk_ack_i;
  logic [DATA_W-1:0] src_data_i;
  logic [RAIL_W-1:0] rxr_rails_i;
  logic              src_ack_o, rxr_ack_o, snk_req_o;
  logic [RAIL_W-1:0] txr_rails_o;
  logic [DATA_W-1:0] snk_data_o;
  logic              rx_full_o, rx_empty_o, rx_err_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  oh_channel_bridge #(.DATA_W(DATA_W)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [RAIL_W-1:0] exp_rails(input int v);
    logic [RAIL_W-1:0] r = '0;
    for (int g = 0; g < GROUPS; g++) r[4*g + ((v >> (2*g)) & 3)] = 1'b1;
    return r;
  endfunction

  function automatic int grp_count(input int p, input int g);
    return $countones((p >> (4*g)) & 15);
  endfunction

  task automatic enc_xfer(input int v);
    logic [RAIL_W-1:0] prev;
    int tog;
    prev = '0;
    tog  = 2;  // rise and fall of the one-hot acknowledge
    @(negedge clk);
    src_data_i = v[DATA_W-1:0];
    src_req_i  = 1'b1;
    @(negedge clk);
    chk("R1 rails for word", txr_rails_o, exp_rails(v));
    chk("R3 no src ack before one-hot ack", src_ack_o, 0);
    tog += $countones(txr_rails_o ^ prev); prev = txr_rails_o;
    repeat (2) @(negedge clk);
    chk("R4 rails held while waiting", txr_rails_o, exp_rails(v));
    chk("R3 src ack still low", src_ack_o, 0);
    tog += $countones(txr_rails_o ^ prev); prev = txr_rails_o;
    txr_ack_i = 1'b1;
    @(negedge clk);
    chk("R3 src ack after full+ack", src_ack_o, 1);
    chk("R2 rails return to zero", txr_rails_o, 0);
    tog += $countones(txr_rails_o ^ prev); prev = txr_rails_o;
    src_req_i = 1'b0;
    txr_ack_i = 1'b0;
    @(negedge clk);
    chk("R3 src ack falls", src_ack_o, 0);
    chk("R2 rails stay empty", txr_rails_o, 0);
    tog += $countones(txr_rails_o ^ prev);
    chk("R5 transitions per transfer", tog, DATA_W + 2);
  endtask

  task automatic dec_xfer(input int v);
    @(negedge clk);
    rxr_rails_i = exp_rails(v);
    #0.5;
    chk("R9 full on complete word", rx_full_o, 1);
    chk("R9 not empty", rx_empty_o, 0);
    @(negedge clk);
    chk("R6 sink request", snk_req_o, 1);
    chk("R6 sink data", snk_data_o, v);
    chk("R7 no one-hot ack before sink ack", rxr_ack_o, 0);
    @(negedge clk);
    chk("R7 one-hot ack still low", rxr_ack_o, 0);
    snk_ack_i = 1'b1;
    @(negedge clk);
    chk("R7 one-hot ack after sink ack", rxr_ack_o, 1);
    chk("R7 sink request drops", snk_req_o, 0);
    rxr_rails_i = '0;
    snk_ack_i   = 1'b0;
    #0.5;
    chk("R9 empty after rtz", rx_empty_o, 1);
    @(negedge clk);
    chk("R8 one-hot ack falls", rxr_ack_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic exp_err;
    rst_n = 1'b0; src_req_i = 1'b0; txr_ack_i = 1'b0; snk_ack_i = 1'b0;
    src_data_i = '0; rxr_rails_i = '0;
    repeat (3) @(negedge clk);
    chk("R11 rails low in reset", txr_rails_o, 0);
    chk("R11 src ack low", src_ack_o, 0);
    chk("R11 one-hot ack low", rxr_ack_o, 0);
    chk("R11 sink req low", snk_req_o, 0);
    chk("R11 err low", rx_err_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < (1 << DATA_W); v++) enc_xfer(v);
    for (int v = 0; v < (1 << DATA_W); v++) dec_xfer(v);
    chk("R10 no error after legal traffic", rx_err_o, 0);

    // partial word: group 0 valid, group 1 empty
    @(negedge clk);
    rxr_rails_i = 8'h02;
    repeat (3) @(negedge clk);
    chk("R6 partial word raises no request", snk_req_o, 0);
    chk("R9 partial word not full", rx_full_o, 0);
    rxr_rails_i = 8'h42;
    @(negedge clk);
    chk("R6 request once word complete", snk_req_o, 1);
    chk("R6 partial then full data", snk_data_o, 4'b1001);
    snk_ack_i = 1'b1;
    @(negedge clk);
    rxr_rails_i = '0; snk_ack_i = 1'b0;
    @(negedge clk);
    chk("R8 ack low after partial case", rxr_ack_o, 0);

    // all rail patterns against arithmetic completion flags
    snk_ack_i = 1'b0;
    exp_err = 1'b0;
    for (int p = 0; p < (1 << RAIL_W); p++) begin
      logic f, m;
      f = 1'b1; m = 1'b0;
      for (int g = 0; g < GROUPS; g++) begin
        if (grp_count(p, g) != 1) f = 1'b0;
        if (grp_count(p, g) > 1)  m = 1'b1;
      end
      @(negedge clk);
      rxr_rails_i = p[RAIL_W-1:0];
      #0.5;
      chk("R9 full flag", rx_full_o, f);
      chk("R9 empty flag", rx_empty_o, (p == 0));
      exp_err = exp_err | m;
      @(negedge clk);
      chk("R10 sticky error", rx_err_o, exp_err);
    end
    @(negedge clk);
    rxr_rails_i = '0;
    repeat (2) @(negedge clk);
    chk("R10 error stays after legal input", rx_err_o, 1);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears error", rx_err_o, 0);
    chk("R11 reset clears one-hot ack", rxr_ack_o, 0);
    chk("R11 reset clears sink req", snk_req_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule